// File: doc/BRIEF.md
# Ethernet MAC Reset Sequencer

This block owns the reset lines of an Ethernet MAC subsystem. It has three reset outputs: an active-high reset for the MAC core, an active-high reset for the external PHY, and an active-low reset for the RMII bridge. When power-on reset is released, the block starts a release sequence by itself. Software can start the same sequence again with a one-cycle request pulse. During the sequence the bridge is held in reset first. The MAC and PHY resets are then asserted together, the PHY is released, the MAC is released, and the bridge is released last. Each of the three middle steps lasts a programmable dwell time. A done flag rises once the last step has completed.

Between sequences, software has a small register write path. A global reset register holds the MAC reset at bit 0 and the PHY reset at bit 4. A bridge control register holds the active-low bridge reset at bit 16. A software stop path writes the MAC bit alone. Reading a non-zero value from the global reset register means a reset is still held. The dwell time is set in clock cycles. The default is 4,000,000 cycles, which is 40 ms at 100 MHz, and a simulation can use a much shorter value.

Top module: `mac_rst_sequencer`

## Requirements
- R1: When power-on reset is released, the block is already running a sequence with no request: MAC reset and PHY reset are 1, bridge reset is 0, done is 0, busy is 1.
- R2: The MAC and PHY resets are held together for exactly DWELL_CYCLES clock cycles. After that the PHY reset goes to 0 and the MAC reset stays at 1.
- R3: The MAC reset goes to 0 exactly DWELL_CYCLES cycles after the PHY reset was released.
- R4: Exactly DWELL_CYCLES cycles after the MAC release, the bridge reset goes to 1 and done goes to 1, both in the same cycle.
- R5: A start request taken while the block is idle asserts the MAC and PHY resets at the next clock edge. At the same edge it drives the bridge reset to 0 and clears done.
- R6: A start request that arrives while a sequence is running is ignored, and the step timing is unchanged.
- R7: busy is 1 from the edge that starts a sequence until the edge that completes it, and done is 0 for that whole time.
- R8: A write to the global reset register (wr_sel=0) while idle sets the MAC reset from data bit 0 and the PHY reset from data bit 4. All other data bits are ignored.
- R9: A write to the bridge control register (wr_sel=1) while idle sets the active-low bridge reset from data bit 16.
- R10: With rd_sel=0, rd_data returns the MAC reset at bit 0 and the PHY reset at bit 4, so the value is non-zero exactly when one of them is held. With rd_sel=1, rd_data returns the bridge reset at bit 16. All other bits read as 0.
- R11: Register writes that arrive while a sequence is running have no effect.
- R12: If a start request and a register write arrive in the same idle cycle, the start request is taken and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| start_req | input | 1 | One-cycle request to run the release sequence |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = global reset register, 1 = bridge control register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target, using the same encoding as wr_sel |
| rd_data | output | 32 | Read data |
| mac_rst | output | 1 | MAC core reset, active high |
| phy_rst | output | 1 | External PHY reset, active high |
| bridge_rst_n | output | 1 | RMII bridge reset, active low |
| seq_done | output | 1 | Sequence has completed |
| busy | output | 1 | A sequence is running |

## Verification
The bench checks the exact edge at which each step happens, for the sequence that starts on its own after reset and for sequences started by a request. A dwell counter that is off by one moves the PHY, MAC or bridge release edge by one cycle. Swapping two steps releases the MAC before the PHY. The bench also sends start requests and register writes in the middle of a sequence. A design that accepts either of them would stretch the dwell or raise a reset again too early. Finally, it sends a request and a write in the same cycle, and it writes words that have extra bits set, to show that only bits 0, 4 and 16 are decoded and that the request wins.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HOLD_ALL = 2'd1,
    ST_PHY_UP   = 2'd2,
    ST_MAC_UP   = 2'd3
  } seq_state_e;

  localparam logic SEL_GLOBAL = 1'b0;
  localparam logic SEL_BRIDGE = 1'b1;
endpackage

// File: rtl/rstseq_dwell_timer.sv
module rstseq_dwell_timer #(
  parameter int DWELL_CYCLES = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // Reset loads the timer so that the first dwell of the automatic sequence is counted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic expire,
  output logic busy,
  output logic go_all,
  output logic rel_phy,
  output logic rel_mac,
  output logic rel_bridge,
  output logic tmr_load
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    go_all     = 1'b0;
    rel_phy    = 1'b0;
    rel_mac    = 1'b0;
    rel_bridge = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_req) begin
        go_all  = 1'b1;
        state_d = ST_HOLD_ALL;
      end
      ST_HOLD_ALL: if (expire) begin
        rel_phy = 1'b1;
        state_d = ST_PHY_UP;
      end
      ST_PHY_UP: if (expire) begin
        rel_mac = 1'b1;
        state_d = ST_MAC_UP;
      end
      ST_MAC_UP: if (expire) begin
        rel_bridge = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Power-on reset enters the first step directly, which gives the automatic start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD_ALL;
    else        state_q <= state_d;
  end

  assign busy     = (state_q != ST_IDLE);
  assign tmr_load = go_all | rel_phy | rel_mac;
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
  import rstseq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAC_BIT    = 0,
  parameter int PHY_BIT    = 4,
  parameter int BRIDGE_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              go_all,
  input  logic              rel_phy,
  input  logic              rel_mac,
  input  logic              rel_bridge,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              mac_rst,
  output logic              phy_rst,
  output logic              bridge_rst_n,
  output logic              seq_done
);
  logic mac_q, phy_q, brg_q, done_q;
  logic sw_ok;

  // A start request takes priority over a write in the same cycle, and writes are dropped while busy.
  assign sw_ok = wr_en & ~busy & ~go_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q  <= 1'b1;
      phy_q  <= 1'b1;
      brg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (go_all) begin
        mac_q  <= 1'b1;
        phy_q  <= 1'b1;
        brg_q  <= 1'b0;
        done_q <= 1'b0;
      end
      if (rel_phy) phy_q <= 1'b0;
      if (rel_mac) mac_q <= 1'b0;
      if (rel_bridge) begin
        brg_q  <= 1'b1;
        done_q <= 1'b1;
      end
      if (sw_ok) begin
        if (wr_sel == SEL_GLOBAL) begin
          mac_q <= wr_data[MAC_BIT];
          phy_q <= wr_data[PHY_BIT];
        end else begin
          brg_q <= wr_data[BRIDGE_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_GLOBAL) begin
      rd_data[MAC_BIT] = mac_q;
      rd_data[PHY_BIT] = phy_q;
    end else begin
      rd_data[BRIDGE_BIT] = brg_q;
    end
  end

  assign mac_rst      = mac_q;
  assign phy_rst      = phy_q;
  assign bridge_rst_n = brg_q;
  assign seq_done     = done_q;
endmodule

// File: rtl/mac_rst_sequencer.sv
module mac_rst_sequencer #(
  parameter int DWELL_CYCLES = 4000000,
  parameter int DATA_W       = 32,
  parameter int MAC_BIT      = 0,
  parameter int PHY_BIT      = 4,
  parameter int BRIDGE_BIT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              mac_rst,
  output logic              phy_rst,
  output logic              bridge_rst_n,
  output logic              seq_done,
  output logic              busy
);
  logic go_all, rel_phy, rel_mac, rel_bridge, tmr_load, expire;

  rstseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .expire     (expire),
    .busy       (busy),
    .go_all     (go_all),
    .rel_phy    (rel_phy),
    .rel_mac    (rel_mac),
    .rel_bridge (rel_bridge),
    .tmr_load   (tmr_load)
  );

  rstseq_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .expire (expire)
  );

  rstseq_regs #(
    .DATA_W     (DATA_W),
    .MAC_BIT    (MAC_BIT),
    .PHY_BIT    (PHY_BIT),
    .BRIDGE_BIT (BRIDGE_BIT)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .go_all       (go_all),
    .rel_phy      (rel_phy),
    .rel_mac      (rel_mac),
    .rel_bridge   (rel_bridge),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .mac_rst      (mac_rst),
    .phy_rst      (phy_rst),
    .bridge_rst_n (bridge_rst_n),
    .seq_done     (seq_done)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic mac_rst,
  input logic phy_rst,
  input logic bridge_rst_n,
  input logic seq_done,
  input logic busy
);
  // R2: the MAC is never released while the PHY is still held
  a_r2_phy_before_mac: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mac_rst) |-> !phy_rst);

  // R4: at completion, both resets are released and the bridge is out of reset
  a_r4_bridge_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> (bridge_rst_n && !mac_rst && !phy_rst));

  // R7: done stays low while a sequence runs
  a_r7_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !seq_done);

  // R5: a request taken while idle asserts everything at the next edge
  a_r5_start_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> (mac_rst && phy_rst && !bridge_rst_n && !seq_done && busy));

  // R11: the PHY reset can only rise from an idle cycle
  a_r11_no_rise_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst) |-> !$past(busy));
endmodule

bind mac_rst_sequencer rstseq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_req    (start_req),
  .mac_rst      (mac_rst),
  .phy_rst      (phy_rst),
  .bridge_rst_n (bridge_rst_n),
  .seq_done     (seq_done),
  .busy         (busy)
);

// File: tb/tb_mac_rst_sequencer.sv
`timescale 1ns/1ps
module tb_mac_rst_sequencer;
  localparam int DW = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        mac_rst, phy_rst, bridge_rst_n, seq_done, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model state
  int m_phase = 1;
  int m_remain = DW;
  bit m_mac = 1, m_phy = 1, m_br = 0, m_done = 0;

  always #5 clk = ~clk;

  mac_rst_sequencer #(.DWELL_CYCLES(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .mac_rst(mac_rst), .phy_rst(phy_rst), .bridge_rst_n(bridge_rst_n),
    .seq_done(seq_done), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: phase 0 idle, 1 both held, 2 phy released, 3 mac released
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 1; m_remain = DW;
      m_mac = 1; m_phy = 1; m_br = 0; m_done = 0;
    end else if (m_phase == 0) begin
      if (start_req) begin
        m_phase = 1; m_remain = DW;
        m_mac = 1; m_phy = 1; m_br = 0; m_done = 0;
      end else if (wr_en) begin
        if (!wr_sel) begin m_mac = wr_data[0]; m_phy = wr_data[4]; end
        else m_br = wr_data[16];
      end
    end else begin
      m_remain--;
      if (m_remain == 0) begin
        case (m_phase)
          1: begin m_phy = 0; m_phase = 2; m_remain = DW; end
          2: begin m_mac = 0; m_phase = 3; m_remain = DW; end
          default: begin m_br = 1; m_done = 1; m_phase = 0; end
        endcase
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 phy_rst", 32'(phy_rst), 32'(m_phy));
      check("R3 mac_rst", 32'(mac_rst), 32'(m_mac));
      check("R4 bridge_rst_n", 32'(bridge_rst_n), 32'(m_br));
      check("R4 seq_done", 32'(seq_done), 32'(m_done));
      check("R7 busy", 32'(busy), 32'(m_phase != 0));
      check("R10 rd_data", rd_data,
            rd_sel ? (32'(m_br) << 16) : ((32'(m_phy) << 4) | 32'(m_mac)));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    step();
    start_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mac after reset", 32'(mac_rst), 32'd1);
    check("R1 phy after reset", 32'(phy_rst), 32'd1);
    check("R1 bridge after reset", 32'(bridge_rst_n), 32'd0);
    check("R1 done after reset", 32'(seq_done), 32'd0);
    step();
    wait_idle();
    step();
    @(negedge clk);
    check("R4 done after auto sequence", 32'(seq_done), 32'd1);

    // R8: only bits 0 and 4 of the global register are decoded
    rd_sel = 1'b0;
    wr(1'b0, 32'h0000_0001);
    @(negedge clk);
    check("R8 stop path mac only", {30'd0, phy_rst, mac_rst}, 32'h1);
    check("R10 nonzero read", rd_data, 32'h1);
    wr(1'b0, 32'hFFFF_FFEE);
    @(negedge clk);
    check("R8 other bits ignored", {30'd0, phy_rst, mac_rst}, 32'h0);
    wr(1'b0, 32'h0000_0010);
    @(negedge clk);
    check("R8 phy only", {30'd0, phy_rst, mac_rst}, 32'h2);
    // R9: bridge control bit 16
    rd_sel = 1'b1;
    wr(1'b1, 32'hFFFE_FFFF);
    @(negedge clk);
    check("R9 bridge held", 32'(bridge_rst_n), 32'd0);
    wr(1'b1, 32'h0001_0000);
    @(negedge clk);
    check("R9 bridge released", rd_data, 32'h0001_0000);

    // R5: request from idle
    rd_sel = 1'b0;
    pulse_start();
    @(negedge clk);
    check("R5 start asserts", {28'd0, seq_done, bridge_rst_n, phy_rst, mac_rst}, 32'h3);
    step();
    // R6: a request in mid-sequence is ignored
    pulse_start();
    // R11: writes in mid-sequence are ignored
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h0001_0000);
    @(negedge clk);
    check("R11 write while busy", {29'd0, bridge_rst_n, phy_rst, mac_rst}, 32'h3);
    wait_idle();
    step();
    check("R6 sequence completed on time", 32'(seq_done), 32'd1);

    // R12: a request and a write in the same cycle
    start_req = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0;
    step();
    start_req = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R12 start wins", {29'd0, busy, phy_rst, mac_rst}, 32'h7);
    wait_idle();
    repeat (3) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule